// File: doc/BRIEF.md
# Standard-Definition Slave Sync Field Detector

This block reads the timing of an incoming standard-definition video stream when the encoder is the timing slave. From the pixel words and the sync pins it works out which field is being received, flags the start of every field with a one-clock strobe, and counts lines and samples within the frame. It also drives a blanking flag. That flag comes from one of three places: the embedded timing codes, an external active-low blanking pin, or, when the pin is not used, a built-in table of the lines that each standard leaves blank.

Four timing schemes can be selected through a 3-bit timing configuration:

- timing words embedded in the pixel data;
- a line-sync pin together with a field pin, where the field pin is qualified by the line sync being low;
- separate line and vertical sync pins, decoded by their falling edges;
- the field-pin scheme qualified by the line sync being high.

All edges are found in the pixel clock domain by comparing each pin with its value at the previous clock. Line sync is active low.

Top module: `sd_field_detect`

## Requirements
- R1: `cfg_timing[2:1]` selects the timing scheme (0 embedded codes, 1 field pin qualified by low line sync, 2 line/vertical edges, 3 field pin qualified by high line sync). When `cfg_timing[0]` is 1 (master), the block produces no strobe and holds field, line, sample and blank outputs unchanged.
- R2: In scheme 0 a timing word is accepted only when it is preceded by three words: all ones, then zero, then zero. The accepted word must have bit DATA_W-1 set. F, V and H sit in bits DATA_W-2, DATA_W-3 and DATA_W-4. The next four bits down must equal {V^H, F^H, F^V, F^V^H}. Any other word is ignored.
- R3: In scheme 0, an accepted word whose F differs from the held field strobes and sets `field_even` to F. `blank_out` follows V|H of the last accepted word. An accepted word with H=1 is a line start.
- R4: In scheme 1, a change of the field pin while the line sync is low strobes, and `field_even` takes the new field-pin level.
- R5: In scheme 2, line sync and vertical sync falling on the same clock start an odd field (`field_even`=0). Vertical sync falling while line sync is high both now and at the previous clock starts an even field (`field_even`=1). Any other combination starts no field.
- R6: In scheme 3, a change of the field pin while the line sync is high strobes, and `field_even` takes the new field-pin level.
- R7: `field_strobe` is high for the one clock after the edge at which the triggering input is sampled. On that edge `line_num` becomes 1 for an odd field, or 263 (`std_pal`=0) / 313 (`std_pal`=1) for an even field.
- R8: A line start increments `line_num` (saturating) and clears `sample_num`. In schemes 1 to 3 a line start is a falling line-sync edge. Otherwise `sample_num` counts up by one per clock and saturates at all ones. A field start takes priority over a line start for `line_num`.
- R9: In schemes 1 to 3 with `blank_pin_en`=1, `blank_out` equals the inverse of `blank_n_in` from the previous clock.
- R10: In schemes 1 to 3 with `blank_pin_en`=0, `blank_out` is 1 exactly on lines 1–21 and 263–284 (`std_pal`=0), or on lines 1–22, 311–335 and 623–625 (`std_pal`=1).
- R11: While `rst_n` is low, `field_even`=0, `field_strobe`=0, `line_num`=0, `sample_num`=0 and `blank_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_timing | input | 3 | [2:1] timing scheme, [0] master select |
| std_pal | input | 1 | 0 = 525-line standard, 1 = 625-line standard |
| blank_pin_en | input | 1 | Use the external blanking pin in schemes 1–3 |
| pix_data | input | DATA_W | Pixel stream carrying embedded timing words |
| hsync_in | input | 1 | Line sync, active low |
| vfield_in | input | 1 | Vertical sync or field pin |
| blank_n_in | input | 1 | External blanking, active low |
| field_even | output | 1 | 1 while an even field is received |
| field_strobe | output | 1 | One-clock pulse at each field start |
| line_num | output | LINE_W | Frame line number |
| sample_num | output | SAMP_W | Samples since the last line start |
| blank_out | output | 1 | Blanking indication |

## Verification
The bench sweeps all sixteen combinations of previous and current line-sync and field-pin levels in every pin scheme, for both standards. A design that ignored the qualifier level, or that treated a rising line sync as high, would strobe where none is expected or would set the wrong field. All eight F/V/H combinations are sent as embedded words in both directions, along with a word with a flipped protection bit and a broken preamble. A decoder that skipped the protection check would switch field on the damaged word. The bench also walks every line of both frames against the blank-line table, which catches off-by-one bounds and a wrong even-field start line. Finally it checks that the sample counter saturates and that master operation freezes every output.

// File: rtl/sd_fd_pkg.sv
package sd_fd_pkg;

    typedef enum logic [1:0] {
        MODE_CODES   = 2'd0,
        MODE_FLD_HLO = 2'd1,
        MODE_HV_EDGE = 2'd2,
        MODE_FLD_HHI = 2'd3
    } sync_mode_e;

    localparam int unsigned EVEN_START_525 = 263;
    localparam int unsigned EVEN_START_625 = 313;

    // Lines blanked by default for each standard
    function automatic logic auto_vblank(input logic [15:0] ln, input logic pal);
        if (pal) begin
            return (ln >= 16'd1 && ln <= 16'd22) ||
                   (ln >= 16'd311 && ln <= 16'd335) ||
                   (ln >= 16'd623 && ln <= 16'd625);
        end
        return (ln >= 16'd1 && ln <= 16'd21) || (ln >= 16'd263 && ln <= 16'd284);
    endfunction

    // Protection nibble for an embedded timing word
    function automatic logic [3:0] code_guard(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/sd_fd_edge.sv
module sd_fd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_in,
    input  logic vf_in,
    output logic hs_prev,
    output logic vf_prev,
    output logic hs_fall,
    output logic vf_fall,
    output logic vf_chg
);
    typedef struct packed {
        logic hs;
        logic vf;
    } pin_st_t;

    pin_st_t st_d, st_q;

    always_comb begin
        st_d.hs = hs_in;
        st_d.vf = vf_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hs <= 1'b1;
            st_q.vf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_prev = st_q.hs;
    assign vf_prev = st_q.vf;
    assign hs_fall = st_q.hs & ~hs_in;
    assign vf_fall = st_q.vf & ~vf_in;
    assign vf_chg  = st_q.vf ^ vf_in;

endmodule

// File: rtl/sd_fd_trs.sv
module sd_fd_trs
    import sd_fd_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_data,
    output logic              hit,
    output logic              code_f,
    output logic              code_v,
    output logic              code_h
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam int unsigned       HIST    = 3;

    typedef struct packed {
        logic [HIST-1:0][DATA_W-1:0] w;
    } hist_st_t;

    hist_st_t st_d, st_q;
    logic [7:0] xy;
    logic       preamble;

    assign xy = pix_data[DATA_W-1 -: 8];

    generate
        if (DATA_W > 8) begin : g_lsb
            logic unused_lsb;
            assign unused_lsb = ^pix_data[DATA_W-9:0];
        end
    endgenerate

    always_comb begin
        st_d.w[0] = pix_data;
        for (int i = 1; i < HIST; i++) begin
            st_d.w[i] = st_q.w[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign preamble = (st_q.w[2] == ALL_ONES) && (st_q.w[1] == '0) && (st_q.w[0] == '0);
    assign code_f   = xy[6];
    assign code_v   = xy[5];
    assign code_h   = xy[4];
    assign hit      = preamble && xy[7] && (xy[3:0] == code_guard(xy[6], xy[5], xy[4]));

endmodule

// File: rtl/sd_fd_field.sv
module sd_fd_field
    import sd_fd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  sync_mode_e mode,
    input  logic       hs_now,
    input  logic       hs_prev,
    input  logic       hs_fall,
    input  logic       vf_now,
    input  logic       vf_fall,
    input  logic       vf_chg,
    input  logic       hit,
    input  logic       code_f,
    output logic       evt,
    output logic       evt_even,
    output logic       field_even,
    output logic       strobe
);
    typedef struct packed {
        logic field_even;
        logic strobe;
    } fld_st_t;

    fld_st_t st_d, st_q;

    always_comb begin
        evt      = 1'b0;
        evt_even = st_q.field_even;
        if (active) begin
            case (mode)
                MODE_CODES: begin
                    if (hit && (code_f != st_q.field_even)) begin
                        evt      = 1'b1;
                        evt_even = code_f;
                    end
                end
                MODE_FLD_HLO: begin
                    if (vf_chg && !hs_now) begin
                        evt      = 1'b1;
                        evt_even = vf_now;
                    end
                end
                MODE_HV_EDGE: begin
                    if (vf_fall && hs_fall) begin
                        evt      = 1'b1;
                        evt_even = 1'b0;
                    end else if (vf_fall && hs_prev && hs_now) begin
                        evt      = 1'b1;
                        evt_even = 1'b1;
                    end
                end
                MODE_FLD_HHI: begin
                    if (vf_chg && hs_now) begin
                        evt      = 1'b1;
                        evt_even = vf_now;
                    end
                end
                default: ;
            endcase
        end
        st_d.field_even = evt ? evt_even : st_q.field_even;
        st_d.strobe     = evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign field_even = st_q.field_even;
    assign strobe     = st_q.strobe;

    AST_FIELD_ONLY_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.strobe |-> $stable(st_q.field_even)); // R7

endmodule

// File: rtl/sd_fd_count.sv
module sd_fd_count
    import sd_fd_pkg::*;
#(
    parameter int unsigned LINE_W = 10,
    parameter int unsigned SAMP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              fs_evt,
    input  logic              fs_even,
    input  logic              std_pal,
    input  logic              line_start,
    input  logic              codes_mode,
    input  logic              use_pin,
    input  logic              blank_n_in,
    input  logic              hit,
    input  logic              code_v,
    input  logic              code_h,
    output logic [LINE_W-1:0] line_num,
    output logic [SAMP_W-1:0] sample_num,
    output logic              blank_out
);
    localparam logic [LINE_W-1:0] LINE_MAX  = '1;
    localparam logic [SAMP_W-1:0] SAMP_MAX  = '1;
    localparam logic [LINE_W-1:0] ODD_LINE  = LINE_W'(1);
    localparam logic [LINE_W-1:0] EVEN_525  = LINE_W'(EVEN_START_525);
    localparam logic [LINE_W-1:0] EVEN_625  = LINE_W'(EVEN_START_625);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [SAMP_W-1:0] samp;
        logic              blank;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (active) begin
            if (fs_evt) begin
                st_d.line = fs_even ? (std_pal ? EVEN_625 : EVEN_525) : ODD_LINE;
            end else if (line_start && (st_q.line != LINE_MAX)) begin
                st_d.line = st_q.line + 1'b1;
            end

            if (line_start) begin
                st_d.samp = '0;
            end else if (st_q.samp != SAMP_MAX) begin
                st_d.samp = st_q.samp + 1'b1;
            end

            if (codes_mode) begin
                st_d.blank = hit ? (code_v | code_h) : st_q.blank;
            end else if (use_pin) begin
                st_d.blank = ~blank_n_in;
            end else begin
                st_d.blank = auto_vblank(16'(st_d.line), std_pal);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line  <= '0;
            st_q.samp  <= '0;
            st_q.blank <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_num   = st_q.line;
    assign sample_num = st_q.samp;
    assign blank_out  = st_q.blank;

    AST_SAMPLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (active && line_start) |=> (st_q.samp == '0)); // R8

endmodule

// File: rtl/sd_field_detect.sv
module sd_field_detect
    import sd_fd_pkg::*;
#(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned LINE_W = 10,
    parameter int unsigned SAMP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_timing,
    input  logic              std_pal,
    input  logic              blank_pin_en,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              hsync_in,
    input  logic              vfield_in,
    input  logic              blank_n_in,
    output logic              field_even,
    output logic              field_strobe,
    output logic [LINE_W-1:0] line_num,
    output logic [SAMP_W-1:0] sample_num,
    output logic              blank_out
);
    sync_mode_e mode;
    logic active, codes_mode, line_start;
    logic hs_prev, vf_prev, hs_fall, vf_fall, vf_chg;
    logic hit, code_f, code_v, code_h;
    logic fs_evt, fs_even;

    assign mode       = sync_mode_e'(cfg_timing[2:1]);
    assign active     = ~cfg_timing[0];
    assign codes_mode = (mode == MODE_CODES);

    sd_fd_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_in   (hsync_in),
        .vf_in   (vfield_in),
        .hs_prev (hs_prev),
        .vf_prev (vf_prev),
        .hs_fall (hs_fall),
        .vf_fall (vf_fall),
        .vf_chg  (vf_chg)
    );

    sd_fd_trs #(.DATA_W(DATA_W)) u_trs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_data (pix_data),
        .hit      (hit),
        .code_f   (code_f),
        .code_v   (code_v),
        .code_h   (code_h)
    );

    sd_fd_field u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .mode       (mode),
        .hs_now     (hsync_in),
        .hs_prev    (hs_prev),
        .hs_fall    (hs_fall),
        .vf_now     (vfield_in),
        .vf_fall    (vf_fall),
        .vf_chg     (vf_chg),
        .hit        (hit),
        .code_f     (code_f),
        .evt        (fs_evt),
        .evt_even   (fs_even),
        .field_even (field_even),
        .strobe     (field_strobe)
    );

    assign line_start = codes_mode ? (hit & code_h) : hs_fall;

    sd_fd_count #(.LINE_W(LINE_W), .SAMP_W(SAMP_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .fs_evt     (fs_evt),
        .fs_even    (fs_even),
        .std_pal    (std_pal),
        .line_start (line_start),
        .codes_mode (codes_mode),
        .use_pin    (blank_pin_en),
        .blank_n_in (blank_n_in),
        .hit        (hit),
        .code_v     (code_v),
        .code_h     (code_h),
        .line_num   (line_num),
        .sample_num (sample_num),
        .blank_out  (blank_out)
    );

    logic unused_vf_prev;
    assign unused_vf_prev = vf_prev;

    AST_MASTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_timing[0] |=> !field_strobe); // R1

    AST_ODD_LINE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (field_strobe && !field_even) |-> (line_num == LINE_W'(1))); // R7

    AST_BLANK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_timing[0] && (cfg_timing[2:1] != 2'd0) && blank_pin_en)
            |=> (blank_out == !$past(blank_n_in))); // R9

endmodule

// File: tb/sd_field_detect_tb.sv
module sd_field_detect_tb_top;
    localparam int DW = 10;
    localparam int LW = 10;
    localparam int SW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_timing = 3'b000;
    logic          std_pal = 1'b0;
    logic          blank_pin_en = 1'b0;
    logic [DW-1:0] pix_data = 10'h040;
    logic          hsync_in = 1'b1;
    logic          vfield_in = 1'b0;
    logic          blank_n_in = 1'b1;
    logic          field_even, field_strobe, blank_out;
    logic [LW-1:0] line_num;
    logic [SW-1:0] sample_num;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    sd_field_detect #(.DATA_W(DW), .LINE_W(LW), .SAMP_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing), .std_pal(std_pal),
        .blank_pin_en(blank_pin_en), .pix_data(pix_data), .hsync_in(hsync_in),
        .vfield_in(vfield_in), .blank_n_in(blank_n_in), .field_even(field_even),
        .field_strobe(field_strobe), .line_num(line_num), .sample_num(sample_num),
        .blank_out(blank_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_vec = n_vec + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] xy_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    function automatic int blank_ref(input int ln, input bit pal);
        if (pal) return ((ln >= 1 && ln <= 22) || (ln >= 311 && ln <= 335) || (ln >= 623)) ? 1 : 0;
        return ((ln >= 1 && ln <= 21) || (ln >= 263 && ln <= 284)) ? 1 : 0;
    endfunction

    task automatic send_word(input logic [DW-1:0] w, input bit good_pre);
        pix_data = 10'h3FF; tick();
        pix_data = 10'h000; tick();
        pix_data = good_pre ? 10'h000 : 10'h004; tick();
        pix_data = w; tick();
    endtask

    initial begin
        int fb, lb, bb, ev, evn, ex_line;
        // R11 reset values
        tick(); tick();
        chk("R11 field", field_even, 0);
        chk("R11 strobe", field_strobe, 0);
        chk("R11 line", line_num, 0);
        chk("R11 sample", sample_num, 0);
        chk("R11 blank", blank_out, 1);
        rst_n = 1'b1;
        tick();

        // R2 R3: embedded codes, all F/V/H combinations, both directions
        cfg_timing = 3'b000;
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 8; k++) begin
                int c;
                logic f, v, h;
                c = pass ? 7 - k : k;
                f = c[2]; v = c[1]; h = c[0];
                fb = field_even; lb = line_num;
                send_word(xy_word(f, v, h), 1'b1);
                ev = (f != fb);
                chk("R3 strobe", field_strobe, ev);
                chk("R3 field", field_even, f);
                chk("R3 blank", blank_out, v | h);
                ex_line = ev ? (f ? 263 : 1) : (h ? lb + 1 : lb);
                chk("R7 line code", line_num, ex_line);
                if (h) chk("R8 sample clr code", sample_num, 0);
                pix_data = 10'h040; tick();
            end
        end
        // R2: damaged protection bit is ignored
        fb = field_even; bb = blank_out; lb = line_num;
        send_word(xy_word(~field_even, 1'b1, 1'b1) ^ 10'h004, 1'b1);
        chk("R2 bad guard strobe", field_strobe, 0);
        chk("R2 bad guard field", field_even, fb);
        chk("R2 bad guard blank", blank_out, bb);
        chk("R2 bad guard line", line_num, lb);
        // R2: broken preamble is ignored
        send_word(xy_word(~field_even, 1'b0, 1'b1), 1'b0);
        chk("R2 bad preamble strobe", field_strobe, 0);
        chk("R2 bad preamble field", field_even, fb);
        pix_data = 10'h040;

        // R4 R5 R6: pin schemes, all previous/current level combinations
        blank_pin_en = 1'b0;
        for (int s = 0; s < 2; s++) begin
            std_pal = s[0];
            for (int m = 1; m < 4; m++) begin
                cfg_timing = {m[1:0], 1'b0};
                for (int i = 0; i < 16; i++) begin
                    logic hp, vp, hn, vn;
                    {hp, vp, hn, vn} = i[3:0];
                    hsync_in = hp; vfield_in = vp; tick();
                    fb = field_even; lb = line_num;
                    hsync_in = hn; vfield_in = vn; tick();
                    ev = 0; evn = fb;
                    if (m == 1 && vp != vn && !hn) begin ev = 1; evn = vn; end
                    if (m == 3 && vp != vn && hn) begin ev = 1; evn = vn; end
                    if (m == 2 && vp && !vn && hp && !hn) begin ev = 1; evn = 0; end
                    if (m == 2 && vp && !vn && hp && hn) begin ev = 1; evn = 1; end
                    ex_line = ev ? (evn ? (s ? 313 : 263) : 1) : ((hp && !hn) ? lb + 1 : lb);
                    case (m)
                        1: chk("R4 strobe", field_strobe, ev);
                        2: chk("R5 strobe", field_strobe, ev);
                        default: chk("R6 strobe", field_strobe, ev);
                    endcase
                    chk("R4 R5 R6 field", field_even, evn);
                    chk("R7 line start", line_num, ex_line);
                end
            end
        end

        // R10: automatic blank table over whole frames
        for (int s = 0; s < 2; s++) begin
            std_pal = s[0];
            cfg_timing = 3'b100;
            hsync_in = 1'b1; vfield_in = 1'b1; tick();
            hsync_in = 1'b0; vfield_in = 1'b0; tick();
            chk("R7 odd line", line_num, 1);
            chk("R10 blank line1", blank_out, 1);
            for (int ln = 2; ln <= (s ? 625 : 525); ln++) begin
                hsync_in = 1'b1; tick();
                hsync_in = 1'b0; tick();
                chk("R8 line inc", line_num, ln);
                chk("R10 auto blank", blank_out, blank_ref(ln, s[0]));
            end
        end

        // R8: sample counting and saturation
        hsync_in = 1'b1; tick();
        hsync_in = 1'b0; tick();
        chk("R8 sample zero", sample_num, 0);
        for (int n = 1; n <= 20; n++) begin
            tick();
            chk("R8 sample count", sample_num, n);
        end
        repeat (2100) tick();
        chk("R8 sample saturate", sample_num, 2047);

        // R9: external blanking pin
        cfg_timing = 3'b010;
        blank_pin_en = 1'b1;
        for (int n = 0; n < 8; n++) begin
            blank_n_in = n[0] ^ n[2];
            tick();
            chk("R9 pin blank", blank_out, blank_n_in ? 0 : 1);
        end
        blank_pin_en = 1'b0;

        // R1: master operation freezes outputs
        cfg_timing = 3'b100;
        hsync_in = 1'b1; vfield_in = 1'b1; tick();
        cfg_timing = 3'b101;
        tick();
        fb = field_even; lb = line_num; bb = blank_out; ev = sample_num;
        for (int i = 0; i < 6; i++) begin
            hsync_in = 1'b0; vfield_in = 1'b0; tick();
            chk("R1 master strobe", field_strobe, 0);
            hsync_in = 1'b1; vfield_in = 1'b1; tick();
        end
        chk("R1 master field", field_even, fb);
        chk("R1 master line", line_num, lb);
        chk("R1 master blank", blank_out, bb);
        chk("R1 master sample", sample_num, ev);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule